// File: doc/BRIEF.md
# Bidirectional Parallel Port Register Interface

This block sits between a host register bus and the pins of a PC-style bidirectional printer port. The host sees three byte registers selected by a 2-bit offset: a data byte, a read-only status byte and a control byte. The block holds the output data latch and the control bits. It applies the fixed inversions between register bits and pins, samples the status pins through a synchronizer, and turns the data lines into inputs when the host asks for reverse mode.

A host programs the port by writing the control byte. Bits 0 to 3 go to four control pins. Bit 4 masks the acknowledge interrupt. Bit 5 reverses the data lines. The host then moves bytes through offset 0. Status is read at offset 1. A timeout flag there is raised by a strobe input and cleared by software. A falling edge on the acknowledge pin produces a one-cycle interrupt pulse.

Top module: `pport_regif`

## Requirements
- R1: After reset the data latch holds 0xFF and `pd_oe` is 1, so `pd_out` drives 0xFF. The control byte reads 0x0C, `ctl_pins` is 4'b0111, the timeout flag is 0 and `irq` is 0.
- R2: The offsets decode as follows. Offset 0 is data, 1 is status and 2 is control. Offset 3 reads 0x00, and a write to it changes none of the registers.
- R3: In output mode (control bit 5 clear), a write to offset 0 appears on `pd_out` in the next cycle, and a read of offset 0 returns the latch.
- R4: `ctl_pins[0]`, `ctl_pins[1]` and `ctl_pins[3]` are the inverse of control bits 0, 1 and 3. `ctl_pins[2]` equals control bit 2.
- R5: Control bits 5:0 read back as written. Control bits 7:6 always read 0.
- R6: While control bit 5 is set, `pd_oe` is 0. A read of offset 0 then returns `pd_in` through a two-flop synchronizer. Writes to offset 0 still load the latch, and the latch is driven again once bit 5 is cleared.
- R7: Status bits 3, 4, 5 and 6 follow `st_pins[0]`, `st_pins[1]`, `st_pins[2]` and `st_pins[3]`. Bit 7 is the inverse of `st_pins[4]` (busy). Bits 2:1 read 1. All pins pass through a two-flop synchronizer, so idle pins that are all high read 0x7E.
- R8: A `tmo_strobe` cycle sets status bit 0. A write to offset 1 with bit 0 set clears it, and if both happen in the same cycle the set wins. Any other effect of writing offset 1 is nil: the data and control registers are unchanged.
- R9: A falling edge on the acknowledge pin `st_pins[3]` gives exactly one `irq` cycle when control bit 4 is clear. It gives none when bit 4 is set, and a rising edge gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register offset |
| wr_en | input | 1 | Write strobe for the selected offset |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte of the selected offset (combinational) |
| pd_in | input | 8 | Sampled data pin levels |
| pd_out | output | 8 | Data latch toward the pins |
| pd_oe | output | 1 | 1 = data pins driven |
| ctl_pins | output | 4 | Control pin levels after inversion |
| st_pins | input | 5 | Status pins: [0..3] to bits 3..6 (ack at [3]), [4] busy |
| tmo_strobe | input | 1 | Sets the timeout flag |
| irq | output | 1 | Acknowledge interrupt pulse |

## Verification
The assertions check four properties on every cycle. A data write lands on `pd_out` one cycle later, and a control write sets the direction one cycle later. `irq` never lasts two cycles and never fires with the mask set. The fixed status and control bits read correctly whenever those offsets are selected. Other behaviour needs the bench's scenarios. These are the pin inversion patterns, the reverse read through the synchronizer and the return to the held latch, the timeout set/clear priority, and the absence of a pulse on a rising acknowledge edge.

// File: rtl/pport_pkg.sv
package pport_pkg;
    localparam int BYTE_W = 8;
    localparam int CTL_W  = 6;

    typedef enum logic [1:0] {
        OFS_DATA = 2'd0,
        OFS_STAT = 2'd1,
        OFS_CTRL = 2'd2,
        OFS_NONE = 2'd3
    } ofs_e;

    typedef struct packed {
        logic [BYTE_W-1:0] dat;
        logic [CTL_W-1:0]  ctl;
        logic              tmo;
    } regs_t;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
    parameter int             W       = 8,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/pport_ctl_map.sv
module pport_ctl_map #(
    parameter int           N        = 4,
    parameter logic [N-1:0] INV_MASK = 4'b1011
) (
    input  logic [N-1:0] bits,
    output logic [N-1:0] pins
);
    for (genvar g = 0; g < N; g++) begin : g_pin
        if (INV_MASK[g]) begin : g_inv
            assign pins[g] = ~bits[g];
        end else begin : g_dir
            assign pins[g] = bits[g];
        end
    end
endmodule

// File: rtl/pport_ack_edge.sv
module pport_ack_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_s,
    input  logic mask,
    output logic irq
);
    typedef struct packed {
        logic prev;
        logic pulse;
    } edge_t;

    edge_t e_d, e_q;

    always_comb begin
        e_d.prev  = ack_s;
        e_d.pulse = e_q.prev & ~ack_s & ~mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '{prev: 1'b1, pulse: 1'b0};
        else        e_q <= e_d;
    end

    assign irq = e_q.pulse;
endmodule

// File: rtl/pport_regif.sv
module pport_regif
    import pport_pkg::*;
#(
    parameter int             SYNC_STAGES  = 2,
    parameter int             ST_W         = 5,
    parameter int             CPIN_W       = 4,
    parameter logic [3:0]     CPIN_INV     = 4'b1011,
    parameter logic [7:0]     DATA_RST     = 8'hFF,
    parameter logic [5:0]     CTL_RST      = 6'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic [7:0]        pd_in,
    output logic [7:0]        pd_out,
    output logic              pd_oe,
    output logic [3:0]        ctl_pins,
    input  logic [ST_W-1:0]   st_pins,
    input  logic              tmo_strobe,
    output logic              irq
);
    localparam int ACK_IDX  = 3;
    localparam int BUSY_IDX = ST_W - 1;
    localparam int REV_BIT  = 5;
    localparam int MSK_BIT  = 4;

    regs_t regs_d, regs_q;
    logic [BYTE_W-1:0] pd_s;
    logic [ST_W-1:0]   st_s;
    logic [BYTE_W-1:0] stat_byte;
    ofs_e              ofs;

    pport_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_dsync (
        .clk(clk), .rst_n(rst_n), .d(pd_in), .q(pd_s)
    );

    pport_sync #(.W(ST_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_ssync (
        .clk(clk), .rst_n(rst_n), .d(st_pins), .q(st_s)
    );

    pport_ctl_map #(.N(CPIN_W), .INV_MASK(CPIN_INV)) u_cmap (
        .bits(regs_q.ctl[CPIN_W-1:0]), .pins(ctl_pins)
    );

    pport_ack_edge u_ack (
        .clk(clk), .rst_n(rst_n), .ack_s(st_s[ACK_IDX]),
        .mask(regs_q.ctl[MSK_BIT]), .irq(irq)
    );

    assign ofs       = ofs_e'(addr);
    assign stat_byte = {~st_s[BUSY_IDX], st_s[ACK_IDX:0], 2'b11, regs_q.tmo};

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (ofs)
                OFS_DATA: regs_d.dat = wr_data;
                OFS_CTRL: regs_d.ctl = wr_data[CTL_W-1:0];
                OFS_STAT: if (wr_data[0]) regs_d.tmo = 1'b0;
                default:  ;
            endcase
        end
        if (tmo_strobe) regs_d.tmo = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{dat: DATA_RST, ctl: CTL_RST, tmo: 1'b0};
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (ofs)
            OFS_DATA: rd_data = regs_q.ctl[REV_BIT] ? pd_s : regs_q.dat;
            OFS_STAT: rd_data = stat_byte;
            OFS_CTRL: rd_data = {2'b00, regs_q.ctl};
            default:  rd_data = '0;
        endcase
    end

    assign pd_out = regs_q.dat;
    assign pd_oe  = ~regs_q.ctl[REV_BIT];
endmodule

// File: rtl/pport_regif_chk.sv
module pport_regif_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] addr,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic [7:0] pd_out,
    input logic       pd_oe,
    input logic       irq,
    input logic       msk_q
);
    // R3
    data_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0) |=> (pd_out == $past(wr_data)));

    // R6
    dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd2) |=> (pd_oe == !$past(wr_data[5])));

    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !$past(msk_q));

    // R7
    stat_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd1) |-> (rd_data[2:1] == 2'b11));

    // R5
    ctl_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd2) |-> (rd_data[7:6] == 2'b00));

    // R8
    stat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1) |=> $stable(pd_out));
endmodule

bind pport_regif pport_regif_chk u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pd_out(pd_out), .pd_oe(pd_oe), .irq(irq),
    .msk_q(regs_q.ctl[4])
);

// File: tb/pport_regif_tb.sv
module pport_regif_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [7:0] pd_in = 8'h00;
    logic [7:0] pd_out;
    logic       pd_oe;
    logic [3:0] ctl_pins;
    logic [4:0] st_pins = 5'b11111;
    logic       tmo_strobe = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;

    typedef struct {
        logic [1:0] a;
        logic [7:0] e;
        string      tag;
    } item_t;
    item_t exp_q[$];

    always #10 clk = ~clk;

    pport_regif u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
        .ctl_pins(ctl_pins), .st_pins(st_pins), .tmo_strobe(tmo_strobe), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected reads and compares in mid high phase
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                chk(it.tag, int'(rd_data), int'(it.e));
            end
        end
    end

    always @(negedge clk) if (rst_n && irq) irq_cnt++;

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        addr = a;
        wr_en = 1'b0;
        exp_q.push_back('{a: a, e: e, tag: tag});
        @(posedge clk);
        #6;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a;
        wr_data = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(4);
        // R1 reset state
        chk("R1 pd_out", pd_out, 8'hFF);
        chk("R1 pd_oe", pd_oe, 1);
        chk("R1 ctl_pins", ctl_pins, 4'b0111);
        chk("R1 irq", irq, 0);
        rd(2'd0, 8'hFF, "R1 data read");
        rd(2'd2, 8'h0C, "R1 ctl read");
        rd(2'd1, 8'h7E, "R1 R7 idle status");
        rd(2'd3, 8'h00, "R2 offset3 read");

        // R3 output mode data
        wr(2'd0, 8'hA5);
        chk("R3 pd_out A5", pd_out, 8'hA5);
        rd(2'd0, 8'hA5, "R3 read A5");
        wr(2'd0, 8'h3C);
        chk("R3 pd_out 3C", pd_out, 8'h3C);

        // R4 control pin inversions
        wr(2'd2, 8'h0B);
        chk("R4 pins for 0B", ctl_pins, 4'b0000);
        wr(2'd2, 8'h04);
        chk("R4 pins for 04", ctl_pins, 4'b1111);
        rd(2'd2, 8'h04, "R5 read 04");

        // R5 / R6 all bits set: reverse + mask
        pd_in = 8'h5A;
        wr(2'd2, 8'hFF);
        rd(2'd2, 8'h3F, "R5 high bits read 0");
        chk("R4 pins for 3F", ctl_pins, 4'b0100);
        chk("R6 pd_oe off", pd_oe, 0);
        idle(3);
        rd(2'd0, 8'h5A, "R6 reverse read pins");
        chk("R6 latch held", pd_out, 8'h3C);
        wr(2'd0, 8'h99);
        rd(2'd0, 8'h5A, "R6 reverse read after write");
        pd_in = 8'hC3;
        idle(3);
        rd(2'd0, 8'hC3, "R6 reverse read new pins");
        wr(2'd2, 8'h0C);
        chk("R6 pd_oe back", pd_oe, 1);
        chk("R6 latch driven", pd_out, 8'h99);
        rd(2'd0, 8'h99, "R6 read latch again");

        // R7 status mapping
        st_pins = 5'b00000;
        idle(3);
        rd(2'd1, 8'h86, "R7 all pins low");
        st_pins = 5'b10101;
        idle(3);
        rd(2'd1, 8'h2E, "R7 mixed pins");

        // R8 timeout flag
        @(negedge clk); tmo_strobe = 1'b1;
        @(negedge clk); tmo_strobe = 1'b0;
        rd(2'd1, 8'h2F, "R8 timeout set");
        wr(2'd1, 8'hFE);
        rd(2'd1, 8'h2F, "R8 write bit0 clear keeps flag");
        rd(2'd0, 8'h99, "R8 data unchanged");
        rd(2'd2, 8'h0C, "R8 ctl unchanged");
        wr(2'd1, 8'h01);
        rd(2'd1, 8'h2E, "R8 flag cleared");
        @(negedge clk);
        addr = 2'd1; wr_data = 8'h01; wr_en = 1'b1; tmo_strobe = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tmo_strobe = 1'b0;
        rd(2'd1, 8'h2F, "R8 set wins over clear");
        wr(2'd1, 8'h01);

        // R2 offset 3 write ignored
        wr(2'd3, 8'h55);
        rd(2'd0, 8'h99, "R2 data after off3 write");
        rd(2'd1, 8'h2E, "R2 status after off3 write");
        rd(2'd2, 8'h0C, "R2 ctl after off3 write");
        rd(2'd3, 8'h00, "R2 off3 still 0");

        // R9 acknowledge interrupt
        st_pins = 5'b11111;
        idle(5);
        irq_cnt = 0;
        st_pins[3] = 1'b0;
        idle(8);
        chk("R9 one pulse on fall", irq_cnt, 1);
        st_pins[3] = 1'b1;
        idle(8);
        chk("R9 no pulse on rise", irq_cnt, 1);
        wr(2'd2, 8'h1C);
        irq_cnt = 0;
        st_pins[3] = 1'b0;
        idle(8);
        chk("R9 masked no pulse", irq_cnt, 0);
        st_pins[3] = 1'b1;
        wr(2'd2, 8'h0C);
        idle(5);
        irq_cnt = 0;
        st_pins[3] = 1'b0;
        idle(8);
        chk("R9 unmasked again", irq_cnt, 1);

        idle(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule